// File: doc/BRIEF.md
# Input Gamma Lookup Table with Sequential Loader

This block maps graphics pixels through a per-channel input lookup table before the rest of the pixel pipeline sees them. Each of the red, green and blue channels owns a 256-entry table of 12-bit unsigned fractions: all bits are fractional and none are integer bits. An 8-bit channel value selects an entry, and the entry comes out one clock later with a valid flag beside it. A mode bit can bypass the table. In bypass, each 8-bit input is widened to 12 bits by copying its top four bits into the new low bits, so full scale stays full scale.

Software loads the tables through a small write-only register port. It first selects the start entry with the index register and sets the channel enable mask. It then sets the power-hold control, which keeps the table memory awake while it is written. After that it streams colour values into one data register. The data writes fall on the enabled channels in red, green, blue order. After the last enabled channel of an entry has been written, the loader moves to the next entry.

Top module: `igam_lut`

## Requirements
- R1: After reset the index is 0, the channel mask is 3'b111, bypass is on, power hold is off, the channel pointer is on red, and `pix_vld_o` is low.
- R2: `cfg_sel` codes: 0 = index register (wdata[7:0]), 1 = channel mask (wdata[2:0], bit 0 red, bit 1 green, bit 2 blue), 2 = mode (wdata[0], 1 = bypass), 3 = power hold (wdata[0]), 4 = colour data (wdata[11:0]). A register takes a write on a clock edge where `cfg_we` is high.
- R3: With all channels enabled, three successive colour writes store red, then green, then blue at the current index.
- R4: After the last enabled channel of an entry is stored, the index increments by one, wrapping from 255 to 0, and the pointer returns to the first enabled channel.
- R5: Channels whose mask bit is clear are skipped in the rotation, and their entries keep their values. With a mask of 0, colour writes store nothing and move neither the index nor the pointer.
- R6: Writing the index register or the mask register returns the pointer to the lowest enabled channel.
- R7: While power hold is 0, colour writes store nothing and move neither the index nor the pointer.
- R8: In lookup mode (mode bit 0), a pixel presented with `pix_vld_i` appears one clock later as the three table entries at its channel values, with `pix_vld_o` high in that same cycle. `pix_vld_o` is low one cycle after a cycle with no valid input.
- R9: In bypass mode, each output one clock after a valid input equals {x[7:0], x[7:4]} for input x. The mode that applies is the one in force in the cycle the pixel enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 12 | Register write data |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_r_i | input | 8 | Input red |
| pix_g_i | input | 8 | Input green |
| pix_b_i | input | 8 | Input blue |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_r_o | output | 12 | Output red, u0.12 |
| pix_g_o | output | 12 | Output green, u0.12 |
| pix_b_o | output | 12 | Output blue, u0.12 |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle valid latency;
- the bypass widening of the red lane;
- the index load;
- the rule that the index steps by at most one per colour write;
- the pointer always resting on an enabled channel;
- the freezing of index and pointer when power hold is off or the mask is empty.

Only the bench's scenarios can show what the tables hold. These scenarios are the full 256-entry load and sweep, the wrap that overwrites entry 0, entries untouched under a partial mask, and the pointer restart after index or mask writes. All of these are observed through the lookup path.

// File: rtl/igam_lut_pkg.sv
package igam_lut_pkg;
   typedef enum logic [2:0] {
      SEL_INDEX = 3'd0,
      SEL_MASK  = 3'd1,
      SEL_MODE  = 3'd2,
      SEL_POWER = 3'd3,
      SEL_DATA  = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/igam_wr_seq.sv
module igam_wr_seq
   import igam_lut_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int CH_N  = 3,
   parameter int VAL_W = 12,
   localparam int PTR_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [VAL_W-1:0] cfg_wdata,
   output logic [IDX_W-1:0] idx_o,
   output logic [PTR_W-1:0] ptr_o,
   output logic [CH_N-1:0]  mask_o,
   output logic             bypass_o,
   output logic             pwr_o,
   output logic [CH_N-1:0]  ch_we_o
);
   logic [IDX_W-1:0] idx_q;
   logic [PTR_W-1:0] ptr_q;
   logic [CH_N-1:0]  mask_q;
   logic             byp_q;
   logic             pwr_q;
   logic [PTR_W-1:0] first_cur;
   logic [PTR_W-1:0] first_new;
   logic [PTR_W-1:0] next_ptr;
   logic             next_found;
   logic             accept;
   logic [CH_N-1:0]  new_mask;
   cfg_sel_e         sel;

   assign sel      = cfg_sel_e'(cfg_sel);
   assign new_mask = cfg_wdata[CH_N-1:0];
   assign accept   = cfg_we && (sel == SEL_DATA) && pwr_q && (|mask_q);

   always_comb begin
      first_cur = '0;
      first_new = '0;
      for (int c = CH_N - 1; c >= 0; c--) begin
         if (mask_q[c])   first_cur = PTR_W'(c);
         if (new_mask[c]) first_new = PTR_W'(c);
      end
   end

   always_comb begin
      next_found = 1'b0;
      next_ptr   = first_cur;
      for (int c = 0; c < CH_N; c++) begin
         if (!next_found && (PTR_W'(c) > ptr_q) && mask_q[c]) begin
            next_found = 1'b1;
            next_ptr   = PTR_W'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         ptr_q  <= '0;
         mask_q <= '1;
         byp_q  <= 1'b1;
         pwr_q  <= 1'b0;
      end else if (cfg_we) begin
         unique case (sel)
            SEL_INDEX: begin
               idx_q <= cfg_wdata[IDX_W-1:0];
               ptr_q <= first_cur;
            end
            SEL_MASK: begin
               mask_q <= new_mask;
               ptr_q  <= first_new;
            end
            SEL_MODE:  byp_q <= cfg_wdata[0];
            SEL_POWER: pwr_q <= cfg_wdata[0];
            SEL_DATA: begin
               if (accept) begin
                  ptr_q <= next_ptr;
                  if (!next_found) idx_q <= idx_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   for (genvar c = 0; c < CH_N; c++) begin : g_we
      assign ch_we_o[c] = accept && (ptr_q == PTR_W'(c));
   end

   assign idx_o    = idx_q;
   assign ptr_o    = ptr_q;
   assign mask_o   = mask_q;
   assign bypass_o = byp_q;
   assign pwr_o    = pwr_q;
endmodule

// File: rtl/igam_chan_ram.sv
module igam_chan_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 12,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/igam_widen.sv
module igam_widen #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 12,
   localparam int EXT  = OUT_W - IN_W
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   assign dout = {din, din[IN_W-1 -: EXT]};
endmodule

// File: rtl/igam_lut.sv
module igam_lut
   import igam_lut_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int VAL_W = 12,
   parameter int CH_N  = 3,
   localparam int PTR_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [VAL_W-1:0] cfg_wdata,
   input  logic             pix_vld_i,
   input  logic [IDX_W-1:0] pix_r_i,
   input  logic [IDX_W-1:0] pix_g_i,
   input  logic [IDX_W-1:0] pix_b_i,
   output logic             pix_vld_o,
   output logic [VAL_W-1:0] pix_r_o,
   output logic [VAL_W-1:0] pix_g_o,
   output logic [VAL_W-1:0] pix_b_o
);
   if (VAL_W <= IDX_W || VAL_W > 2 * IDX_W) begin : g_bad_width
      $error("igam_lut: VAL_W must lie in (IDX_W, 2*IDX_W]");
   end
   if (CH_N != 3 || IDX_W > VAL_W) begin : g_bad_chan
      $error("igam_lut: three channels and IDX_W <= VAL_W required");
   end

   logic [IDX_W-1:0] idx_q;
   logic [PTR_W-1:0] ptr_q;
   logic [CH_N-1:0]  mask_q;
   logic             bypass_q;
   logic             pwr_q;
   logic [CH_N-1:0]  ch_we;
   logic [IDX_W-1:0] pix_in  [CH_N];
   logic [VAL_W-1:0] lut_rd  [CH_N];
   logic [VAL_W-1:0] wide_d  [CH_N];
   logic [VAL_W-1:0] wide_q  [CH_N];
   logic [VAL_W-1:0] pix_out [CH_N];
   logic             vld_q;
   logic             byp_sel_q;

   assign pix_in[0] = pix_r_i;
   assign pix_in[1] = pix_g_i;
   assign pix_in[2] = pix_b_i;

   igam_wr_seq #(.IDX_W(IDX_W), .CH_N(CH_N), .VAL_W(VAL_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .idx_o    (idx_q),
      .ptr_o    (ptr_q),
      .mask_o   (mask_q),
      .bypass_o (bypass_q),
      .pwr_o    (pwr_q),
      .ch_we_o  (ch_we)
   );

   for (genvar c = 0; c < CH_N; c++) begin : g_chan
      igam_chan_ram #(.ADDR_W(IDX_W), .DATA_W(VAL_W)) u_ram (
         .clk  (clk),
         .we   (ch_we[c]),
         .waddr(idx_q),
         .wdata(cfg_wdata),
         .re   (pix_vld_i),
         .raddr(pix_in[c]),
         .rdata(lut_rd[c])
      );

      igam_widen #(.IN_W(IDX_W), .OUT_W(VAL_W)) u_wide (
         .din (pix_in[c]),
         .dout(wide_d[c])
      );

      always_ff @(posedge clk) begin
         if (pix_vld_i) wide_q[c] <= wide_d[c];
      end

      assign pix_out[c] = byp_sel_q ? wide_q[c] : lut_rd[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         byp_sel_q <= 1'b1;
      end else begin
         vld_q <= pix_vld_i;
         if (pix_vld_i) byp_sel_q <= bypass_q;
      end
   end

   assign pix_vld_o = vld_q;
   assign pix_r_o   = pix_out[0];
   assign pix_g_o   = pix_out[1];
   assign pix_b_o   = pix_out[2];
endmodule

// File: rtl/igam_lut_chk.sv
module igam_lut_chk #(
   parameter int IDX_W = 8,
   parameter int VAL_W = 12,
   parameter int CH_N  = 3,
   localparam int PTR_W = (CH_N > 1) ? $clog2(CH_N) : 1,
   localparam int EXT   = VAL_W - IDX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [2:0]       cfg_sel,
   input logic [VAL_W-1:0] cfg_wdata,
   input logic             pix_vld_i,
   input logic [IDX_W-1:0] pix_r_i,
   input logic             pix_vld_o,
   input logic [VAL_W-1:0] pix_r_o,
   input logic [IDX_W-1:0] idx_q,
   input logic [PTR_W-1:0] ptr_q,
   input logic [CH_N-1:0]  mask_q,
   input logic             bypass_q,
   input logic             pwr_q
);
   logic data_wr;
   assign data_wr = cfg_we && (cfg_sel == 3'd4);

   p_vld_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_i |=> pix_vld_o);
   p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld_i |=> !pix_vld_o);
   p_bypass_widen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld_i && bypass_q) |=>
         (pix_r_o == {$past(pix_r_i), $past(pix_r_i[IDX_W-1 -: EXT])}));
   p_index_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 3'd0) |=> (idx_q == $past(cfg_wdata[IDX_W-1:0])));
   p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> ((idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 1'b1)));
   p_pwr_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !pwr_q) |=> ($stable(idx_q) && $stable(ptr_q)));
   p_mask_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && mask_q == '0) |=> ($stable(idx_q) && $stable(ptr_q)));
   p_ptr_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q != '0) |-> mask_q[ptr_q]);
   p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q < PTR_W'(CH_N));
endmodule

bind igam_lut igam_lut_chk #(.IDX_W(IDX_W), .VAL_W(VAL_W), .CH_N(CH_N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_sel  (cfg_sel),
   .cfg_wdata(cfg_wdata),
   .pix_vld_i(pix_vld_i),
   .pix_r_i  (pix_r_i),
   .pix_vld_o(pix_vld_o),
   .pix_r_o  (pix_r_o),
   .idx_q    (idx_q),
   .ptr_q    (ptr_q),
   .mask_q   (mask_q),
   .bypass_q (bypass_q),
   .pwr_q    (pwr_q)
);

// File: tb/igam_lut_bench.sv
module igam_lut_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [11:0] cfg_wdata = '0;
   logic        pix_vld_i = 1'b0;
   logic [7:0]  pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
   logic        pix_vld_o;
   logic [11:0] pix_r_o, pix_g_o, pix_b_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model of the tables and loader state, built from the requirements
   logic [11:0] exp_t [3][256];
   int m_idx = 0, m_ptr = 0;
   logic [2:0] m_mask = 3'b111;
   bit m_pwr = 1'b0;

   always #2 clk = ~clk;

   igam_lut u_igam_lut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .pix_vld_i(pix_vld_i), .pix_r_i(pix_r_i),
      .pix_g_i(pix_g_i), .pix_b_i(pix_b_i), .pix_vld_o(pix_vld_o),
      .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
   );

   function automatic int first_en(logic [2:0] m);
      for (int c = 0; c < 3; c++) if (m[c]) return c;
      return 0;
   endfunction

   function automatic logic [11:0] widen(logic [7:0] x);
      return {x, x[7:4]};
   endfunction

   task automatic check(string req, logic [35:0] act, logic [35:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(logic [2:0] sel, logic [11:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         3'd0: begin m_idx = int'(d[7:0]); m_ptr = first_en(m_mask); end
         3'd1: begin m_mask = d[2:0]; m_ptr = first_en(m_mask); end
         3'd3: m_pwr = d[0];
         3'd4: if (m_pwr && m_mask != 0) begin
            int nxt;
            exp_t[m_ptr][m_idx] = d;
            nxt = -1;
            for (int c = 2; c > m_ptr; c--) if (m_mask[c]) nxt = c;
            if (nxt < 0) begin
               m_ptr = first_en(m_mask);
               m_idx = (m_idx + 1) % 256;
            end else m_ptr = nxt;
         end
         default: ;
      endcase
   endtask

   task automatic pixel(string req, logic [7:0] r, logic [7:0] g, logic [7:0] b, bit byp);
      logic [35:0] e;
      @(negedge clk);
      pix_vld_i = 1'b1; pix_r_i = r; pix_g_i = g; pix_b_i = b;
      @(negedge clk);
      pix_vld_i = 1'b0;
      if (byp) e = {widen(r), widen(g), widen(b)};
      else     e = {exp_t[0][r], exp_t[1][g], exp_t[2][b]};
      check(req, {pix_vld_o, pix_r_o, pix_g_o, pix_b_o}, {1'b1, e});
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: valid low after reset, bypass on by default
      check("R1 valid low", {35'd0, pix_vld_o}, 36'd0);
      pixel("R1 R9 bypass default", 8'hA5, 8'h0F, 8'hF0, 1'b1);
      // R1: index starts at 0 and pointer at red, R7 power hold needed
      cfg_write(3'd3, 12'd1);
      cfg_write(3'd4, 12'h111);
      cfg_write(3'd4, 12'h222);
      cfg_write(3'd4, 12'h333);
      cfg_write(3'd2, 12'd0);
      pixel("R1 R3 index zero at reset", 8'd0, 8'd0, 8'd0, 1'b0);
      // R3 R4: full load from index 0
      cfg_write(3'd0, 12'd0);
      for (int i = 0; i < 256; i++)
         for (int c = 0; c < 3; c++)
            cfg_write(3'd4, 12'((i * 37 + c * 1000 + 5) & 12'hFFF));
      for (int i = 0; i < 256; i++)
         pixel("R8 R3 lookup sweep", 8'(i), 8'(i + 85), 8'(255 - i), 1'b0);
      // R4: index wrapped to 0, next set overwrites entry 0
      cfg_write(3'd4, 12'hABC);
      cfg_write(3'd4, 12'hDEF);
      cfg_write(3'd4, 12'h012);
      pixel("R4 wrap to entry 0", 8'd0, 8'd0, 8'd0, 1'b0);
      pixel("R4 entry 1 untouched", 8'd1, 8'd1, 8'd1, 1'b0);
      // R5: green only
      cfg_write(3'd1, 12'b010);
      cfg_write(3'd0, 12'd10);
      cfg_write(3'd4, 12'h0A1);
      cfg_write(3'd4, 12'h0A2);
      cfg_write(3'd4, 12'h0A3);
      for (int i = 10; i < 13; i++)
         pixel("R5 green only mask", 8'(i), 8'(i), 8'(i), 1'b0);
      // R5: red and blue
      cfg_write(3'd1, 12'b101);
      cfg_write(3'd0, 12'd20);
      cfg_write(3'd4, 12'h0B1);
      cfg_write(3'd4, 12'h0B2);
      cfg_write(3'd4, 12'h0B3);
      pixel("R5 red blue mask e20", 8'd20, 8'd20, 8'd20, 1'b0);
      pixel("R5 red blue mask e21", 8'd21, 8'd21, 8'd21, 1'b0);
      // R6: index write restarts pointer
      cfg_write(3'd1, 12'b111);
      cfg_write(3'd0, 12'd30);
      cfg_write(3'd4, 12'h0C1);
      cfg_write(3'd0, 12'd30);
      cfg_write(3'd4, 12'h0C2);
      pixel("R6 index write restarts red", 8'd30, 8'd30, 8'd30, 1'b0);
      // R6: mask write restarts pointer
      cfg_write(3'd0, 12'd40);
      cfg_write(3'd4, 12'h0D1);
      cfg_write(3'd4, 12'h0D2);
      cfg_write(3'd1, 12'b111);
      cfg_write(3'd4, 12'h0D3);
      pixel("R6 mask write restarts red", 8'd40, 8'd40, 8'd40, 1'b0);
      // R5: empty mask ignores data
      cfg_write(3'd0, 12'd50);
      cfg_write(3'd1, 12'b000);
      cfg_write(3'd4, 12'h0E1);
      cfg_write(3'd1, 12'b100);
      cfg_write(3'd4, 12'h0E2);
      pixel("R5 empty mask ignored", 8'd50, 8'd50, 8'd50, 1'b0);
      pixel("R5 empty mask index kept", 8'd51, 8'd51, 8'd51, 1'b0);
      // R7: power hold off ignores data
      cfg_write(3'd1, 12'b111);
      cfg_write(3'd0, 12'd60);
      cfg_write(3'd3, 12'd0);
      cfg_write(3'd4, 12'h0F1);
      cfg_write(3'd3, 12'd1);
      cfg_write(3'd4, 12'h0F2);
      pixel("R7 power hold gate", 8'd60, 8'd60, 8'd60, 1'b0);
      pixel("R7 power hold index kept", 8'd61, 8'd61, 8'd61, 1'b0);
      // R9: bypass sweep
      cfg_write(3'd2, 12'd1);
      for (int i = 0; i < 256; i += 3)
         pixel("R9 bypass sweep", 8'(i), 8'(i ^ 8'h5A), 8'(~i), 1'b1);
      // R9 R2: mode change takes effect for the next pixel
      cfg_write(3'd2, 12'd0);
      pixel("R9 back to lookup", 8'd77, 8'd78, 8'd79, 1'b0);
      // R8: valid drops after an idle cycle
      @(negedge clk);
      check("R8 valid idle", {35'd0, pix_vld_o}, 36'd0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule